// File: doc/BRIEF.md
# ADC Control Register Sequencer

This block is the digital control logic of a multi-channel successive-approximation converter. The analog core is outside it. A host bus drives chip select, write strobe, read strobe, a register-select line, a high-byte enable, an 8-bit data bus and a two-bit channel address. The block decodes that traffic into a small control register, which sets the output latch mode, the hardware sample/hold trigger mode and power down, and can request a calibration. From these settings the block sequences start pulses for conversion and calibration toward the core, and it waits on the core's done and overflow inputs. Calibration and conversion therefore last as many cycles as the core takes.

The bus strobes and the calibration pin are asynchronous. Each passes through a synchronizer chain of `SYNC_STAGES` flops and is then edge-detected. A bus access takes effect on the rising edge of the write strobe. The trigger input and the supply-fail pulse are taken as synchronous to the clock. Power down is a sleep state and not a lockout: one-shot conversions and calibrations still run while it is set, and the core returns to sleep by itself once the work is done.

Top module: `adc_ctrl_seq`

## Requirements
- R1: After reset, every output is low, `chan` is 0 and no operation is in progress.
- R2: A bus write is accepted when `wr_n` rises while `cs_n` is low and `rd_n` is high. It takes effect at the (SYNC_STAGES+1)-th clock edge after the rise. If `sel_reg` and `hi_byte` are both high, the write is a register write. If `sel_reg` is low, it is a data write. If `sel_reg` is high and `hi_byte` is low, the write is ignored: no field changes and nothing starts.
- R3: A register write with data bit 1 low starts one conversion. `conv_start` pulses for one cycle, and `busy` stays high from that edge until `conv_done` is seen.
- R4: A register write loads data bit 0 into `latch_mode` (1 = latched, 0 = transparent), bit 2 into `sh_mode` and bit 3 into `pd_mode`. Bit 5 low clears `pfail` and bit 5 high leaves it unchanged. Bits 4, 6 and 7 have no effect.
- R5: A register write with data bit 1 high pulses `cal_start`. Every calibration is followed by exactly one conversion: `conv_start` pulses at the edge where `cal_done` is seen, and `busy` stays high until `conv_done`. The two start pulses are never high together.
- R6: `core_sleep` is high when `pd_mode` is set and nothing is running. A conversion started while `pd_mode` is set drops `core_sleep`. When `conv_done` arrives, `core_sleep` rises again and `pd_mode` is unchanged.
- R7: Power down is left by a register write with bit 3 low, or by a falling edge on `cal_n`. The falling edge also starts a calibration. A register write with bits 1 and 3 both high keeps `pd_mode`, runs a calibration and then a conversion, and `core_sleep` returns once both are done.
- R8: A `supply_fail` pulse clears `latch_mode` and `sh_mode`, sets `pd_mode` and `pfail`, aborts any running operation and pulses `cal_start` at the next edge.
- R9: `cal_err` is cleared at every calibration start. It is set if `cal_ovf` is high during a calibration, and it stays low if the calibration finishes without overflow.
- R10: While `sh_mode` is set, the first clock edge at which `trig` is high after having been low pulses `conv_start`. While `sh_mode` is clear, `trig` starts nothing.
- R11: A data write latches `addr` into `chan`. Outside sample/hold mode it also starts a conversion. In sample/hold mode it starts nothing.
- R12: A start request that arrives while `busy` is high is dropped and sets `overrun`, which stays set until reset. The control fields of such a write are still loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| sel_reg | input | 1 | Selects the control register |
| hi_byte | input | 1 | High-byte enable |
| din | input | 8 | Write data |
| addr | input | 2 | Channel address |
| cal_n | input | 1 | Calibration request pin, falling edge active |
| trig | input | 1 | Sample/hold trigger, synchronous |
| supply_fail | input | 1 | Supply-fail event pulse, synchronous |
| conv_done | input | 1 | Core finished a conversion |
| cal_done | input | 1 | Core finished a calibration |
| cal_ovf | input | 1 | Core overflow during calibration |
| conv_start | output | 1 | One-cycle conversion start pulse |
| cal_start | output | 1 | One-cycle calibration start pulse |
| busy | output | 1 | Conversion or calibration in progress |
| core_sleep | output | 1 | Analog core powered off |
| latch_mode | output | 1 | Output latch mode, 1 = latched |
| sh_mode | output | 1 | Sample/hold trigger mode enabled |
| pd_mode | output | 1 | Power down requested |
| pfail | output | 1 | Power-fail flag |
| cal_err | output | 1 | Calibration overflow flag |
| overrun | output | 1 | Sticky dropped-request flag |
| chan | output | 2 | Latched channel address |

## Verification
A wrong sequencer state shows up as a start pulse that is missing, doubled or of the wrong kind. It can also show as a `busy` level that does not follow the done inputs, and it is visible at the same edge the request lands, which is SYNC_STAGES+1 edges after the strobe rises. A corrupted control field shows one clock after the write edge: `core_sleep` stays low when it should be high, a trigger that is or is not honoured, or a data write that converts when it should not. Flag errors in `cal_err`, `pfail` and `overrun` persist, so they can be observed at any later sample until the next event that clears them.

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       sel_reg,
  input  logic       hi_byte,
  input  logic [7:0] din,
  input  logic [1:0] addr,
  input  logic       cal_n,
  input  logic       trig,
  input  logic       supply_fail,
  input  logic       conv_done,
  input  logic       cal_done,
  input  logic       cal_ovf,
  output logic       conv_start,
  output logic       cal_start,
  output logic       busy,
  output logic       core_sleep,
  output logic       latch_mode,
  output logic       sh_mode,
  output logic       pd_mode,
  output logic       pfail,
  output logic       cal_err,
  output logic       overrun,
  output logic [1:0] chan
);
  localparam int NB = 6;
  localparam logic [NB-1:0] IDLE_LVL = 6'b100111;
  localparam int LS = SYNC_STAGES - 1;

  typedef enum logic [1:0] {S_IDLE, S_CAL, S_CONV} st_t;
  st_t st;

  logic [NB-1:0] sync_q [SYNC_STAGES];
  logic [NB-1:0] last_q;
  logic          trig_q;
  logic          unused_bits;

  assign unused_bits = ^{din[7:6], din[4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= IDLE_LVL;
      last_q <= IDLE_LVL;
      trig_q <= 1'b0;
    end else begin
      sync_q[0] <= {cal_n, hi_byte, sel_reg, rd_n, wr_n, cs_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      last_q <= sync_q[LS];
      trig_q <= trig;
    end
  end

  logic wr_ev, reg_wr, dat_wr, cal_ev, trg_ev, want_cal, want_conv;

  assign wr_ev     = sync_q[LS][1] & ~last_q[1] & ~last_q[0] & last_q[2];
  assign reg_wr    = wr_ev & last_q[3] & last_q[4];
  assign dat_wr    = wr_ev & ~last_q[3];
  assign cal_ev    = ~sync_q[LS][5] & last_q[5];
  assign trg_ev    = sh_mode & trig & ~trig_q;
  assign want_cal  = cal_ev | (reg_wr & din[1]);
  assign want_conv = (reg_wr & ~din[1]) | (dat_wr & ~sh_mode) | trg_ev;

  assign busy       = (st != S_IDLE);
  assign core_sleep = pd_mode & (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      conv_start <= 1'b0;
      cal_start  <= 1'b0;
      latch_mode <= 1'b0;
      sh_mode    <= 1'b0;
      pd_mode    <= 1'b0;
      pfail      <= 1'b0;
      cal_err    <= 1'b0;
      overrun    <= 1'b0;
      chan       <= '0;
    end else begin
      conv_start <= 1'b0;
      cal_start  <= 1'b0;
      if (supply_fail) begin
        latch_mode <= 1'b0;
        sh_mode    <= 1'b0;
        pd_mode    <= 1'b1;
        pfail      <= 1'b1;
        cal_err    <= 1'b0;
        cal_start  <= 1'b1;
        st         <= S_CAL;
      end else begin
        if (reg_wr) begin
          latch_mode <= din[0];
          sh_mode    <= din[2];
          pd_mode    <= din[3];
          if (!din[5]) pfail <= 1'b0;
        end
        if (cal_ev) pd_mode <= 1'b0;
        if (dat_wr) chan <= addr;
        if (busy && (want_cal || want_conv)) overrun <= 1'b1;
        case (st)
          S_IDLE: begin
            if (want_cal) begin
              st        <= S_CAL;
              cal_start <= 1'b1;
              cal_err   <= 1'b0;
            end else if (want_conv) begin
              st         <= S_CONV;
              conv_start <= 1'b1;
            end
          end
          S_CAL: begin
            if (cal_ovf) cal_err <= 1'b1;
            if (cal_done) begin
              st         <= S_CONV;
              conv_start <= 1'b1;
            end
          end
          S_CONV: begin
            if (conv_done) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (conv_start || cal_start));

  // R5
  start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_start, cal_start}));

  // R5
  cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> busy);

  // R9
  cal_err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> !cal_err);

  // R12
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R8
  supply_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_fail |=> (cal_start && pd_mode && pfail && !sh_mode));

endmodule

// File: tb/sim_adc_ctrl_seq.sv
`timescale 1ns/100ps
module sim_adc_ctrl_seq;
  localparam int SYNC = 2;
  localparam int LAT  = SYNC + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, sel_reg = 1'b0, hi_byte = 1'b0;
  logic [7:0] din = '0;
  logic [1:0] addr = '0;
  logic cal_n = 1'b1, trig = 1'b0, supply_fail = 1'b0;
  logic conv_done = 1'b0, cal_done = 1'b0, cal_ovf = 1'b0;
  logic conv_start, cal_start, busy, core_sleep;
  logic latch_mode, sh_mode, pd_mode, pfail, cal_err, overrun;
  logic [1:0] chan;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_ctrl_seq #(.SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .sel_reg(sel_reg), .hi_byte(hi_byte), .din(din), .addr(addr),
    .cal_n(cal_n), .trig(trig), .supply_fail(supply_fail),
    .conv_done(conv_done), .cal_done(cal_done), .cal_ovf(cal_ovf),
    .conv_start(conv_start), .cal_start(cal_start), .busy(busy),
    .core_sleep(core_sleep), .latch_mode(latch_mode), .sh_mode(sh_mode),
    .pd_mode(pd_mode), .pfail(pfail), .cal_err(cal_err), .overrun(overrun),
    .chan(chan)
  );

  // {expect_cal, pd, sh, latch, data}
  localparam logic [11:0] VEC [7] = '{
    12'h101, 12'h000, 12'h408, 12'h802, 12'hC0A, 12'h305, 12'h000
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic s, input logic h, input logic [7:0] d, input logic [1:0] a);
    @(negedge clk);
    din = d; addr = a; sel_reg = s; hi_byte = h; cs_n = 1'b0;
    @(negedge clk); wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (LAT) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic end_conv();
    conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic end_cal();
    cal_done = 1'b1;
    @(negedge clk); cal_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 starts", {conv_start, cal_start}, 0);
    chk("R1 flags", {latch_mode, sh_mode, pd_mode, pfail, cal_err, overrun, core_sleep}, 0);
    chk("R1 chan", chan, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R7: register write table
    foreach (VEC[i]) begin
      bus_wr(1'b1, 1'b1, VEC[i][7:0], 2'd0);
      chk("R4 fields", {pd_mode, sh_mode, latch_mode}, VEC[i][10:8]);
      chk("R5 cal_start", cal_start, VEC[i][11]);
      chk("R3 conv_start", conv_start, !VEC[i][11]);
      chk("R3 busy", busy, 1);
      chk("R6 awake", core_sleep, 0);
      if (VEC[i][11]) begin
        @(negedge clk);
        chk("R5 busy in cal", busy, 1);
        end_cal();
        chk("R5 conv after cal", conv_start, 1);
      end
      @(negedge clk);
      chk("R3 single pulse", conv_start, 0);
      end_conv();
      chk("R3 busy end", busy, 0);
      chk("R7 sleep return", core_sleep, VEC[i][10]);
    end

    // R2 reserved combination
    bus_wr(1'b1, 1'b0, 8'h0D, 2'd1);
    chk("R2 reserved no start", {conv_start, cal_start, busy}, 0);
    chk("R2 reserved no field", {pd_mode, sh_mode, latch_mode}, 0);
    chk("R2 reserved chan", chan, 0);

    // R6 R11 one-shot conversion in power down
    bus_wr(1'b1, 1'b1, 8'h08, 2'd0);
    end_conv();
    chk("R6 asleep", core_sleep, 1);
    bus_wr(1'b0, 1'b0, 8'h00, 2'd2);
    chk("R11 data write conv", conv_start, 1);
    chk("R11 chan latched", chan, 2);
    chk("R6 woke", core_sleep, 0);
    end_conv();
    chk("R6 back asleep", {core_sleep, pd_mode}, 2'b11);

    // R7 R9 calibration pin with overflow
    @(negedge clk); cal_n = 1'b0;
    repeat (LAT) @(negedge clk);
    chk("R7 pin cal_start", cal_start, 1);
    chk("R7 pd left", {pd_mode, core_sleep}, 0);
    cal_n = 1'b1;
    cal_ovf = 1'b1;
    @(negedge clk); cal_ovf = 1'b0;
    chk("R9 cal_err set", cal_err, 1);
    end_cal();
    chk("R5 conv after pin cal", conv_start, 1);
    end_conv();
    chk("R9 cal_err held", cal_err, 1);
    bus_wr(1'b1, 1'b1, 8'h02, 2'd0);
    chk("R9 cleared at start", {cal_start, cal_err}, 2'b10);
    end_cal();
    chk("R9 clean cal", cal_err, 0);
    end_conv();

    // R12 overrun
    bus_wr(1'b1, 1'b1, 8'h00, 2'd0);
    chk("R12 first conv", conv_start, 1);
    bus_wr(1'b1, 1'b1, 8'h01, 2'd0);
    chk("R12 dropped start", conv_start, 0);
    chk("R12 fields loaded", latch_mode, 1);
    chk("R12 overrun set", overrun, 1);
    end_conv();
    chk("R12 one conv only", busy, 0);
    repeat (3) @(negedge clk);
    chk("R12 overrun sticky", overrun, 1);

    // R10 R11 sample/hold mode
    bus_wr(1'b1, 1'b1, 8'h04, 2'd0);
    end_conv();
    chk("R10 sh on", sh_mode, 1);
    trig = 1'b1;
    @(negedge clk);
    chk("R10 trig start", conv_start, 1);
    trig = 1'b0;
    @(negedge clk);
    chk("R10 single pulse", conv_start, 0);
    end_conv();
    bus_wr(1'b0, 1'b0, 8'h00, 2'd3);
    chk("R11 no conv in sh", {conv_start, busy}, 0);
    chk("R11 chan in sh", chan, 3);
    bus_wr(1'b1, 1'b1, 8'h00, 2'd0);
    end_conv();
    trig = 1'b1;
    @(negedge clk);
    chk("R10 trig ignored", {conv_start, busy}, 0);
    @(negedge clk);
    chk("R10 trig ignored later", busy, 0);
    trig = 1'b0;

    // R8 R4 supply fail and power-fail flag
    bus_wr(1'b1, 1'b1, 8'h05, 2'd0);
    end_conv();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk("R8 busy before fail", busy, 1);
    supply_fail = 1'b1;
    @(negedge clk); supply_fail = 1'b0;
    chk("R8 cal_start", cal_start, 1);
    chk("R8 flags", {pfail, pd_mode, sh_mode, latch_mode}, 4'b1100);
    chk("R8 busy", busy, 1);
    end_cal();
    chk("R8 conv after cal", conv_start, 1);
    end_conv();
    chk("R8 sleep", core_sleep, 1);
    bus_wr(1'b1, 1'b1, 8'h20, 2'd0);
    end_conv();
    chk("R4 bit5 high keeps pfail", {pfail, pd_mode}, 2'b10);
    bus_wr(1'b1, 1'b1, 8'h00, 2'd0);
    end_conv();
    chk("R4 bit5 low clears pfail", pfail, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule